// File: doc/BRIEF.md
# I/O-Mapped Remote Memory Window

This block gives a host CPU byte-wide read access to the full 64K memory space of a second, remote CPU through the host's I/O space. The remote CPU must first have released its bus and be signalling bus acknowledge. The host then writes the upper half of the wanted remote address into a latch with an I/O write. It reads the byte with an I/O read whose upper address byte supplies the lower half of the remote address.

The lower half comes straight from host address bits 15..8. These carry the byte-counter register during a register-indirect block I/O read. A build option inverts those bits, so a block-input instruction that counts its counter down steps the remote address upward, and data can be moved in forward order. The same read decode pulls the remote memory-request and read strobes low so that the remote memory decoding answers. The remote address and strobe outputs are enabled only while acknowledge is present. Otherwise they are released, and the strobes read back as inactive, as pull-ups would leave them.

Top module: `rmt_mem_window`

## Requirements
- R1: An I/O write with host address bit 7 low (iorq and wr both low) loads host_data_i into the high-address latch at the next rising clock edge, visible on rmt_addr_o[15:8].
- R2: An I/O write with host address bit 7 high, or a write strobe without iorq, leaves the high-address latch unchanged.
- R3: After reset the high-address latch holds 0x00.
- R4: With LO_INVERT=0, rmt_addr_o[7:0] equals host_addr_i[15:8].
- R5: With LO_INVERT=1, rmt_addr_o[7:0] equals the bitwise inverse of host_addr_i[15:8], so a counter value of N gives remote low address 255-N.
- R6: An I/O read with address bit 7 low while rmt_ack_ni is low sets host_data_oe_o to 1 and places rmt_data_i on host_data_o.
- R7: rmt_mreq_no and rmt_rd_no are low exactly when an I/O read with address bit 7 low occurs while rmt_ack_ni is low; otherwise both are high.
- R8: rmt_addr_oe_o and rmt_strobe_oe_o are 1 exactly when rmt_ack_ni is low.
- R9: An I/O read with address bit 7 low while rmt_ack_ni is high returns 0xFF on host_data_o with host_data_oe_o at 1.
- R10: An I/O read with address bit 7 high leaves host_data_oe_o at 0 and the remote strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 16 | Host address bus |
| host_iorq_ni | input | 1 | Host I/O request, active low |
| host_rd_ni | input | 1 | Host read strobe, active low |
| host_wr_ni | input | 1 | Host write strobe, active low |
| host_data_i | input | 8 | Host data bus, write direction |
| host_data_o | output | 8 | Data returned to host |
| host_data_oe_o | output | 1 | Drive enable for host_data_o |
| rmt_ack_ni | input | 1 | Remote bus acknowledge, active low |
| rmt_addr_o | output | 16 | Remote address |
| rmt_addr_oe_o | output | 1 | Drive enable for rmt_addr_o |
| rmt_mreq_no | output | 1 | Remote memory request, active low |
| rmt_rd_no | output | 1 | Remote read strobe, active low |
| rmt_strobe_oe_o | output | 1 | Drive enable for remote strobes |
| rmt_data_i | input | 8 | Remote memory data |

## Verification
The hardest case is a decoded read while acknowledge is absent. The data port must then answer 0xFF, and the strobes must stay released even though the host decode is active. The bench reaches this by toggling rmt_ack_ni around otherwise identical reads. The inverted and plain low-address variants are instantiated side by side and swept over all 256 counter values, and the latch is swept over all 256 data values with interleaved non-matching writes.

// File: rtl/rmt_win_pkg.sv
package rmt_win_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t lo_map(input byte_t cnt, input bit inv);
    return inv ? ~cnt : cnt;
  endfunction
endpackage

// File: rtl/rmt_port_decode.sv
module rmt_port_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PORT_BIT = 7
) (
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_iorq_ni,
  input  logic              host_rd_ni,
  input  logic              host_wr_ni,
  output logic              wr_sel_o,
  output logic              rd_sel_o
);
  logic port_hit;
  assign port_hit = ~host_addr_i[PORT_BIT] & ~host_iorq_ni;
  assign wr_sel_o = port_hit & ~host_wr_ni;
  assign rd_sel_o = port_hit & ~host_rd_ni;
endmodule

// File: rtl/rmt_hi_latch.sv
module rmt_hi_latch
  import rmt_win_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  byte_t data_i,
  output byte_t hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_o <= '0;
    else if (load_i) hi_o <= data_i;
  end

  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> hi_o == $past(data_i));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(hi_o));
endmodule

// File: rtl/rmt_read_path.sv
module rmt_read_path
  import rmt_win_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_sel_i,
  input  logic  ack_ni,
  input  byte_t rmt_data_i,
  output byte_t host_data_o,
  output logic  host_data_oe_o,
  output logic  mreq_no,
  output logic  rd_no
);
  logic fetch;
  assign fetch          = rd_sel_i & ~ack_ni;
  assign host_data_oe_o = rd_sel_i;
  // undriven remote data bus floats high
  assign host_data_o    = fetch ? rmt_data_i : '1;
  // released strobes read back high via pull-ups
  assign mreq_no        = ~fetch;
  assign rd_no          = ~fetch;

  p_no_ack_ff_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i && ack_ni) |-> host_data_o == '1);
  p_strobe_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_no == rd_no);
endmodule

// File: rtl/rmt_mem_window.sv
module rmt_mem_window
  import rmt_win_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PORT_BIT  = 7,
  parameter bit          LO_INVERT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_iorq_ni,
  input  logic              host_rd_ni,
  input  logic              host_wr_ni,
  input  logic [7:0]        host_data_i,
  output logic [7:0]        host_data_o,
  output logic              host_data_oe_o,
  input  logic              rmt_ack_ni,
  output logic [ADDR_W-1:0] rmt_addr_o,
  output logic              rmt_addr_oe_o,
  output logic              rmt_mreq_no,
  output logic              rmt_rd_no,
  output logic              rmt_strobe_oe_o,
  input  logic [7:0]        rmt_data_i
);
  localparam int unsigned LO_W = ADDR_W - BYTE_W;

  logic  wr_sel, rd_sel;
  byte_t hi_q, lo_cnt;

  rmt_port_decode #(.ADDR_W(ADDR_W), .PORT_BIT(PORT_BIT)) u_dec (
    .host_addr_i (host_addr_i),
    .host_iorq_ni(host_iorq_ni),
    .host_rd_ni  (host_rd_ni),
    .host_wr_ni  (host_wr_ni),
    .wr_sel_o    (wr_sel),
    .rd_sel_o    (rd_sel)
  );

  rmt_hi_latch u_hi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wr_sel),
    .data_i(host_data_i),
    .hi_o  (hi_q)
  );

  rmt_read_path u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_sel_i      (rd_sel),
    .ack_ni        (rmt_ack_ni),
    .rmt_data_i    (rmt_data_i),
    .host_data_o   (host_data_o),
    .host_data_oe_o(host_data_oe_o),
    .mreq_no       (rmt_mreq_no),
    .rd_no         (rmt_rd_no)
  );

  assign lo_cnt = host_addr_i[ADDR_W-1 -: BYTE_W];

  generate
    if (LO_W > BYTE_W) begin : g_wide
      assign rmt_addr_o = {hi_q, {(LO_W-BYTE_W){1'b0}}, lo_map(lo_cnt, LO_INVERT)};
    end else begin : g_std
      assign rmt_addr_o = {hi_q, lo_map(lo_cnt, LO_INVERT)};
    end
  endgenerate

  assign rmt_addr_oe_o   = ~rmt_ack_ni;
  assign rmt_strobe_oe_o = ~rmt_ack_ni;

  logic unused_addr;
  assign unused_addr = ^host_addr_i;

  p_strobe_needs_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rmt_mreq_no |-> (rmt_strobe_oe_o && !rmt_ack_ni && host_data_oe_o));
  p_oe_follows_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmt_addr_oe_o == rmt_strobe_oe_o);
  p_read_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rmt_rd_no |-> host_data_o == rmt_data_i);
endmodule

// File: tb/rmt_mem_window_tb.sv
module rmt_mem_window_tb;
  logic        clk = 0, rst_ni = 0;
  logic [15:0] addr = 16'h00FF;
  logic        iorq_n = 1, rd_n = 1, wr_n = 1, ack_n = 1;
  logic [7:0]  hdi = 0, rdat = 0;
  logic [7:0]  hdo_a, hdo_b;
  logic        hoe_a, hoe_b, aoe_a, aoe_b, mreq_a, mreq_b, rdn_a, rdn_b, soe_a, soe_b;
  logic [15:0] ra_a, ra_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rmt_mem_window #(.LO_INVERT(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .host_addr_i(addr), .host_iorq_ni(iorq_n),
    .host_rd_ni(rd_n), .host_wr_ni(wr_n), .host_data_i(hdi), .host_data_o(hdo_a),
    .host_data_oe_o(hoe_a), .rmt_ack_ni(ack_n), .rmt_addr_o(ra_a), .rmt_addr_oe_o(aoe_a),
    .rmt_mreq_no(mreq_a), .rmt_rd_no(rdn_a), .rmt_strobe_oe_o(soe_a), .rmt_data_i(rdat));

  rmt_mem_window #(.LO_INVERT(1'b1)) u_dut_inv (
    .clk_i(clk), .rst_ni(rst_ni), .host_addr_i(addr), .host_iorq_ni(iorq_n),
    .host_rd_ni(rd_n), .host_wr_ni(wr_n), .host_data_i(hdi), .host_data_o(hdo_b),
    .host_data_oe_o(hoe_b), .rmt_ack_ni(ack_n), .rmt_addr_o(ra_b), .rmt_addr_oe_o(aoe_b),
    .rmt_mreq_no(mreq_b), .rmt_rd_no(rdn_b), .rmt_strobe_oe_o(soe_b), .rmt_data_i(rdat));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d, input logic use_iorq);
    @(negedge clk);
    addr = a; hdi = d; iorq_n = ~use_iorq; wr_n = 0;
    @(negedge clk);
    iorq_n = 1; wr_n = 1; addr = 16'h00FF;
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] hi_exp;
    #25; rst_ni = 1;
    @(negedge clk);
    chk("R3 reset latch", ra_a[15:8], 8'h00);
    chk("R3 reset latch inv", ra_b[15:8], 8'h00);
    chk("R8 idle oe", {15'd0, aoe_a}, 16'd0);
    chk("R7 idle strobes", {14'd0, mreq_a, rdn_a}, 16'h3);

    // R1/R2 sweep of latch values with non-matching writes in between
    hi_exp = 8'h00;
    for (int v = 0; v < 256; v++) begin
      io_write({v[7:0], 8'h7E ^ v[6:0]}, v[7:0], 1'b1);
      hi_exp = v[7:0];
      chk("R1 latch load", ra_a[15:8], {8'h00, hi_exp});
      chk("R1 latch load inv", ra_b[15:8], {8'h00, hi_exp});
      io_write({v[7:0], 8'h80 | v[6:0]}, ~v[7:0], 1'b1);
      chk("R2 bit7 high ignored", ra_a[15:8], {8'h00, hi_exp});
      io_write(16'h0000, 8'h5A ^ v[7:0], 1'b0);
      chk("R2 no iorq ignored", ra_a[15:8], {8'h00, hi_exp});
    end

    // R4/R5/R6/R7/R8 read sweep with ack
    io_write(16'h0000, 8'h3C, 1'b1);
    @(negedge clk);
    ack_n = 0;
    for (int c = 0; c < 256; c++) begin
      addr = {c[7:0], 8'h7E};
      rdat = c[7:0] ^ 8'hA5;
      iorq_n = 0; rd_n = 0;
      #2;
      chk("R4 plain low addr", ra_a, {8'h3C, c[7:0]});
      chk("R5 inverted low addr", ra_b, {8'h3C, 8'd255 - c[7:0]});
      chk("R6 read data", {7'd0, hoe_a, hdo_a}, {7'd0, 1'b1, c[7:0] ^ 8'hA5});
      chk("R7 strobes low", {14'd0, mreq_b, rdn_b}, 16'h0);
      chk("R8 oe with ack", {14'd0, aoe_a, soe_b}, 16'h3);
      @(negedge clk);
    end
    // R10 bit7 high read
    addr = 16'h1280; #2;
    chk("R10 no data oe", {15'd0, hoe_a}, 16'd0);
    chk("R10 strobes high", {14'd0, mreq_a, rdn_a}, 16'h3);
    // R7 read strobe without iorq
    addr = 16'h1200; iorq_n = 1; #2;
    chk("R7 no iorq strobes high", {14'd0, mreq_a, rdn_a}, 16'h3);
    // R9 no ack
    iorq_n = 0; ack_n = 1; rdat = 8'h11; #2;
    chk("R9 no ack returns FF", {7'd0, hoe_a, hdo_a}, {7'd0, 1'b1, 8'hFF});
    chk("R7 no ack strobes high", {14'd0, mreq_b, rdn_b}, 16'h3);
    chk("R8 oe without ack", {14'd0, aoe_a, soe_a}, 16'h0);
    ack_n = 0; #2;
    chk("R6 ack restored", {8'd0, hdo_a}, 16'h0011);
    iorq_n = 1; rd_n = 1; ack_n = 1;
    // R3 reset mid-run
    @(negedge clk); rst_ni = 0; #2;
    chk("R3 async reset", ra_a[15:8], 8'h00);
    rst_ni = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule